// File: doc/BRIEF.md
# Tear-free split 64-bit register reader

This block is a bus-master helper. It reads a 64-bit counter through a bus that carries only 32-bit transfers. Between two separate word reads, the counter can carry from its low half into its high half. To catch that, the block reads the high word, then the low word, then the high word again. It accepts the pair only when both high-word samples agree. If they do not agree, it retries a bounded number of times. After the last failed attempt it returns a not-ready sentinel.

The block also provides a zeroing operation that clears both halves with two 32-bit writes.

A client drives `start_i` for one cycle with an operation select and a base address. It then waits for the one-cycle `done_o` pulse, which carries the 64-bit result and a success flag.

Top module: `wide_read_guard`

## Requirements
- R1: A read (`op_i`=0) issues its bus reads in this order: the high word at base+4, the low word at base, then the high word at base+4.
- R2: When the high word read after the low word equals the one read before it, the result is {high, low} and `valid_o`=1.
- R3: When the two high words differ, the block reads the low word and the high word again. The most recent high word becomes the one that the next high read is compared against.
- R4: At most 3 low/high passes are made, so a read uses at most 7 transfers. If the third pass still mismatches, `data_o` is 64'h8000_0000_0000_0000 and `valid_o`=0.
- R5: A zero operation (`op_i`=1) writes 0 to base, then writes 0 to base+4, with `bus_we_o`=1. It finishes with `valid_o`=1 and `data_o`=0.
- R6: `done_o` is high for exactly one cycle per operation. No bus request is active in that cycle.
- R7: A `start_i` pulse that arrives while an operation is in progress is ignored. It adds no transfers and does not change the running operation or its result.
- R8: A request keeps `bus_req_o`, `bus_addr_o` and `bus_we_o` steady until `bus_ack_i` arrives. At most one transfer is outstanding at a time.
- R9: During and right after reset, `done_o` and `bus_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| op_i | input | 1 | 0 = tear-checked read, 1 = zero both halves |
| base_i | input | ADDR_W | Address of the low word |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | 1 = result is genuine, 0 = not-ready sentinel |
| data_o | output | 64 | Result of the last operation |
| bus_req_o | output | 1 | Transfer request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transfer address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge; read data valid in this cycle |
| bus_rdata_i | input | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a carry that lands between the low-word read and the following high-word read. It has to happen on one, two or all three passes. The bench's bus responder models the counter itself. After a chosen number of low-word reads, it adds a programmed increment to the counter, so the high word changes exactly between the two samples. The same mechanism produces recovery on the second pass, recovery on the final pass, and a sentinel after three torn passes. The responder also varies its acknowledge latency, which exercises the hold-until-acknowledge behaviour.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_H0, ST_RD_LO, ST_RD_HI, ST_WR_LO, ST_WR_HI, ST_DONE
  } wrg_state_e;
  localparam logic OP_READ = 1'b0;
  localparam logic OP_ZERO = 1'b1;
endpackage

// File: rtl/wrg_seq.sv
module wrg_seq import wrg_pkg::*; #(
  parameter int RETRY_MAX = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic op_i,
  input  logic bus_ack_i,
  input  logic hi_match_i,
  output logic clr_o,
  output logic cap_h0_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic fin_ok_o,
  output logic fin_fail_o,
  output logic fin_zero_o,
  output logic bus_req_o,
  output logic bus_we_o,
  output logic hi_sel_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(RETRY_MAX + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_MAX - 1);

  wrg_state_e st_q;
  logic [CNT_W-1:0] tries_q;
  logic last_try;

  assign last_try   = (tries_q == LAST);
  assign clr_o      = (st_q == ST_IDLE) && start_i;
  assign cap_h0_o   = (st_q == ST_RD_H0) && bus_ack_i;
  assign cap_lo_o   = (st_q == ST_RD_LO) && bus_ack_i;
  assign cap_hi_o   = (st_q == ST_RD_HI) && bus_ack_i;
  assign fin_ok_o   = cap_hi_o && hi_match_i;
  assign fin_fail_o = cap_hi_o && !hi_match_i && last_try;
  assign fin_zero_o = (st_q == ST_WR_HI) && bus_ack_i;
  assign bus_req_o  = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign bus_we_o   = (st_q == ST_WR_LO) || (st_q == ST_WR_HI);
  assign hi_sel_o   = (st_q == ST_RD_H0) || (st_q == ST_RD_HI) || (st_q == ST_WR_HI);
  assign done_o     = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tries_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          tries_q <= '0;
          st_q    <= (op_i == OP_ZERO) ? ST_WR_LO : ST_RD_H0;
        end
        ST_RD_H0: if (bus_ack_i) st_q <= ST_RD_LO;
        ST_RD_LO: if (bus_ack_i) st_q <= ST_RD_HI;
        ST_RD_HI: if (bus_ack_i) begin
          tries_q <= tries_q + 1'b1;
          if (hi_match_i || last_try) st_q <= ST_DONE;
          else                        st_q <= ST_RD_LO;
        end
        ST_WR_LO: if (bus_ack_i) st_q <= ST_WR_HI;
        ST_WR_HI: if (bus_ack_i) st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wrg_dp.sv
module wrg_dp #(
  parameter int ADDR_W = 32,
  parameter int DW     = 32,
  parameter int HI_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              cap_h0_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              fin_ok_i,
  input  logic              fin_fail_i,
  input  logic              fin_zero_i,
  input  logic              hi_sel_i,
  input  logic [DW-1:0]     rdata_i,
  output logic              hi_match_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2*DW-1:0]   data_o,
  output logic              valid_o
);
  localparam logic [2*DW-1:0] SENTINEL = {1'b1, {(2*DW-1){1'b0}}};

  logic [ADDR_W-1:0] base_q;
  logic [DW-1:0]     hi_prev_q, hi_new_q, lo_q;

  assign hi_match_o = (rdata_i == hi_prev_q);
  assign addr_o     = base_q + (hi_sel_i ? ADDR_W'(HI_OFS) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      hi_prev_q <= '0;
      hi_new_q  <= '0;
      lo_q      <= '0;
      data_o    <= '0;
      valid_o   <= 1'b0;
    end else begin
      if (clr_i) begin
        base_q    <= base_i;
        hi_prev_q <= '0;
        hi_new_q  <= '0;
        lo_q      <= '0;
      end
      if (cap_h0_i || cap_hi_i) hi_new_q <= rdata_i;
      if (cap_lo_i) begin
        lo_q      <= rdata_i;
        hi_prev_q <= hi_new_q;
      end
      if (fin_ok_i) begin
        data_o  <= {rdata_i, lo_q};
        valid_o <= 1'b1;
      end else if (fin_fail_i) begin
        data_o  <= SENTINEL;
        valid_o <= 1'b0;
      end else if (fin_zero_i) begin
        data_o  <= '0;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wide_read_guard.sv
module wide_read_guard #(
  parameter int ADDR_W    = 32,
  parameter int RETRY_MAX = 3,
  parameter int HI_OFS    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              done_o,
  output logic              valid_o,
  output logic [63:0]       data_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i
);
  logic clr, cap_h0, cap_lo, cap_hi, fin_ok, fin_fail, fin_zero, hi_sel, hi_match;

  assign bus_wdata_o = '0;

  wrg_seq #(.RETRY_MAX(RETRY_MAX)) u_seq (
    .clk_i, .rst_ni, .start_i, .op_i, .bus_ack_i,
    .hi_match_i(hi_match), .clr_o(clr), .cap_h0_o(cap_h0), .cap_lo_o(cap_lo),
    .cap_hi_o(cap_hi), .fin_ok_o(fin_ok), .fin_fail_o(fin_fail), .fin_zero_o(fin_zero),
    .bus_req_o, .bus_we_o, .hi_sel_o(hi_sel), .done_o
  );

  wrg_dp #(.ADDR_W(ADDR_W), .DW(32), .HI_OFS(HI_OFS)) u_dp (
    .clk_i, .rst_ni, .clr_i(clr), .base_i,
    .cap_h0_i(cap_h0), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .fin_ok_i(fin_ok), .fin_fail_i(fin_fail), .fin_zero_i(fin_zero),
    .hi_sel_i(hi_sel), .rdata_i(bus_rdata_i), .hi_match_o(hi_match),
    .addr_o(bus_addr_o), .data_o, .valid_o
  );
endmodule

// File: rtl/wrg_chk.sv
module wrg_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              valid_o,
  input logic [63:0]       data_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ack_i
);
  a_r8_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_quiet_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

  a_r4_sentinel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !valid_o |-> data_o == 64'h8000_0000_0000_0000);

  a_r5_zero_wdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> bus_wdata_o == 32'h0);
endmodule

bind wide_read_guard wrg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .done_o, .valid_o, .data_o, .bus_req_o, .bus_we_o,
  .bus_addr_o, .bus_wdata_o, .bus_ack_i
);

// File: tb/sim_wide_read_guard.sv
`timescale 1ns/1ps
module sim_wide_read_guard;
  logic clk = 0, rst_n = 0;
  logic start = 0, op = 0;
  logic [31:0] base = 0;
  logic done, valid, req, we, ack = 0;
  logic [63:0] data;
  logic [31:0] addr, wdata, rdata = 0;

  always #4 clk = ~clk;

  wide_read_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .base_i(base),
    .done_o(done), .valid_o(valid), .data_o(data),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  int errors = 0, checks = 0;
  // responder model
  logic [63:0] cnt = 0, load_val = 0, bump_val = 0;
  logic load_req = 0;
  int lat = 0, wcnt = 0, nx = 0, lo_reads = 0, bump_until = 0, nwr = 0;
  logic [31:0] alog [32];
  logic        wlog [32];

  always @(posedge clk) begin
    ack <= 1'b0;
    if (load_req) cnt <= load_val;
    else if (req && !ack) begin
      if (wcnt >= lat) begin
        wcnt <= 0;
        ack  <= 1'b1;
        alog[nx % 32] <= addr;
        wlog[nx % 32] <= we;
        nx <= nx + 1;
        if (we) begin
          nwr <= nwr + 1;
          if (addr[2]) cnt[63:32] <= wdata; else cnt[31:0] <= wdata;
        end else if (addr[2]) begin
          rdata <= cnt[63:32];
        end else begin
          rdata <= cnt[31:0];
          lo_reads <= lo_reads + 1;
          if (lo_reads < bump_until) cnt <= cnt + bump_val;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req_s, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic preset(input logic [63:0] v, input int l, input int nbump, input logic [63:0] bv);
    @(negedge clk);
    load_val = v; load_req = 1; lat = l; bump_val = bv; bump_until = lo_reads + nbump;
    @(negedge clk);
    load_req = 0;
  endtask

  // start one op, optionally pulse a second start while busy; waits for done
  task automatic run_op(input logic o, input logic [31:0] b, input bit poke,
                        output logic [63:0] d, output logic v, output int n0);
    int t;
    n0 = nx;
    @(negedge clk);
    start = 1; op = o; base = b;
    @(negedge clk);
    start = 0;
    if (poke) begin
      @(negedge clk);
      start = 1; op = ~o; base = 32'hDEAD_0000;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    if (t >= 500) chk(0, "watchdog", 0, 1);
    d = data; v = valid;
    @(negedge clk);
    chk(!done, "R6 done one cycle", 64'(done), 0);
  endtask

  task automatic t_reset;
    chk(!done && !req, "R9 in reset", {req, done}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!done && !req, "R9 after reset", {req, done}, 0);
  endtask

  task automatic t_plain;
    logic [63:0] d; logic v; int n0;
    preset(64'h1234_5678_9ABC_DEF0, 0, 0, 0);
    run_op(0, 32'h1000, 0, d, v, n0);
    chk(d == 64'h1234_5678_9ABC_DEF0 && v, "R2 plain read", d, 64'h1234_5678_9ABC_DEF0);
    chk(nx - n0 == 3, "R1 transfer count", nx - n0, 3);
    chk(alog[n0%32] == 32'h1004 && alog[(n0+1)%32] == 32'h1000 && alog[(n0+2)%32] == 32'h1004,
        "R1 address order", {alog[n0%32], alog[(n0+1)%32]}, {32'h1004, 32'h1000});
  endtask

  task automatic t_tear_once;
    logic [63:0] d; logic v; int n0;
    preset(64'h0000_0001_FFFF_FFF0, 2, 1, 64'h20);
    run_op(0, 32'h1000, 0, d, v, n0);
    chk(d == 64'h0000_0002_0000_0010 && v, "R3 retry after carry", d, 64'h0000_0002_0000_0010);
    chk(nx - n0 == 5 && alog[(n0+3)%32] == 32'h1000, "R3 retry transfers", nx - n0, 5);
  endtask

  task automatic t_tear_twice;
    logic [63:0] d; logic v; int n0;
    preset(64'h0000_0005_0000_0000, 1, 2, 64'h1_0000_0000);
    run_op(0, 32'h1000, 0, d, v, n0);
    chk(d == 64'h0000_0007_0000_0000 && v, "R4 last pass wins", d, 64'h0000_0007_0000_0000);
    chk(nx - n0 == 7, "R4 seven transfers", nx - n0, 7);
  endtask

  task automatic t_tear_fail;
    logic [63:0] d; logic v; int n0;
    preset(64'h0000_0005_0000_0000, 0, 3, 64'h1_0000_0000);
    run_op(0, 32'h1000, 0, d, v, n0);
    chk(d == 64'h8000_0000_0000_0000, "R4 sentinel", d, 64'h8000_0000_0000_0000);
    chk(!v, "R4 valid low", 64'(v), 0);
    chk(nx - n0 == 7, "R4 bounded retries", nx - n0, 7);
  endtask

  task automatic t_zero;
    logic [63:0] d; logic v; int n0, w0;
    preset(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    w0 = nwr;
    run_op(1, 32'h2000, 0, d, v, n0);
    chk(d == 0 && v, "R5 zero result", d, 0);
    chk(nx - n0 == 2 && nwr - w0 == 2, "R5 two writes", nx - n0, 2);
    chk(alog[n0%32] == 32'h2000 && alog[(n0+1)%32] == 32'h2004 && wlog[n0%32] && wlog[(n0+1)%32],
        "R5 write order", {alog[n0%32], alog[(n0+1)%32]}, {32'h2000, 32'h2004});
    chk(cnt == 0, "R5 counter cleared", cnt, 0);
    run_op(0, 32'h2000, 0, d, v, n0);
    chk(d == 0 && v, "R5 read back zero", d, 0);
  endtask

  task automatic t_busy;
    logic [63:0] d; logic v; int n0, w0;
    preset(64'h0000_00AA_0000_0055, 2, 0, 0);
    w0 = nwr;
    run_op(0, 32'h3000, 1, d, v, n0);
    chk(d == 64'h0000_00AA_0000_0055 && v, "R7 busy start ignored", d, 64'h0000_00AA_0000_0055);
    chk(nx - n0 == 3 && nwr == w0, "R7 no extra transfers", nx - n0, 3);
    repeat (3) @(negedge clk);
    chk(!req && !done, "R7 stays idle", {req, done}, 0);
    chk(alog[n0%32] == 32'h3004, "R8 latched base", alog[n0%32], 32'h3004);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plain();
        t_tear_once();
        t_tear_twice();
        t_tear_fail();
        t_zero();
        t_busy();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "global watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule